// File: doc/BRIEF.md
# Register Scoreboard Wakeup Unit

This block keeps one readiness bit for every renamed physical register and a small window of instruction entries. Each entry holds up to two source operands. Each operand has a register tag and a pending bit. When an instruction is written into a slot, the unit decides for each operand whether it must wait. An operand waits only if all three of these hold:
- the rename stage did not already mark it ready;
- its index falls inside the tracked range;
- its scoreboard bit is still clear.

An instruction that names a destination register takes ownership of that register, and the register's scoreboard bit is cleared.

A completing producer broadcasts one register tag per cycle. Every entry compares the tag against its pending operands in parallel and drops the matching pending bits. The scoreboard bit for that register is then set. An entry whose operands are all satisfied raises its ready flag one cycle later. A squash carries a sequence number and removes every entry that is younger than it. The issue logic outside the block reads the per-entry ready and occupied flags. Allocating a producer for a register that still has waiters raises a one-cycle error pulse.

Top module: `sbw_wakeup_unit`

## Requirements
- R1: After reset, every scoreboard bit is not-ready, no entry is occupied, every ready flag is 0 and the error flag is 0. A reset asserted mid-run restores this state, so a source register that was ready before the reset waits afterwards.
- R2: An operand whose rename-ready input bit (bit s of `ins_src_rdy` for operand s) is 1 is never left pending.
- R3: An operand that is not rename-ready, but whose register has its scoreboard bit set at insertion, is accepted as ready and creates no waiter.
- R4: Register indices at or above NUM_PREGS are untracked. They never create a pending operand, never raise the error flag, and a completion naming one changes no entry and no scoreboard bit.
- R5: A completion on a tracked register clears every pending operand with that tag in every occupied entry, and sets that register's scoreboard bit.
- R6: `entry_ready[e]` rises at the second rising edge after the cycle in which slot e was loaded with no pending operand, or in which its last pending operand was woken. It is 0 whenever the slot is empty or has an operand pending.
- R7: When an insertion and a completion name the same tracked register in the same cycle, the completion wins and the new operand is not pending.
- R8: Inserting an instruction with a valid tracked destination clears that register's scoreboard bit. If a completion names the same register in the same cycle, the bit still ends clear.
- R9: Allocating a tracked destination register while an occupied entry has an operand pending on it drives `alloc_err` high for exactly one cycle, starting at the next rising edge.
- R10: A squash invalidates every entry whose sequence number is larger (unsigned) than `sq_seq`. The entry's ready flag is 0 from the next edge, and it holds no pending operand afterwards. Older and equal entries keep their pending state. An insertion in the same cycle with a sequence number larger than `sq_seq` is dropped, and its destination does not allocate.
- R11: Inserting into an occupied slot replaces its contents, and the slot's ready flag is 0 from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_slot | input | log2(NUM_ENTRIES) | Entry written by the insertion |
| ins_seq | input | 8 | Sequence number of the inserted instruction |
| ins_src_tags | input | 12 | Two 6-bit source register tags, operand 0 in bits 5:0 |
| ins_src_rdy | input | 2 | Per-operand ready flag supplied by rename |
| ins_dst_valid | input | 1 | Inserted instruction writes a destination register |
| ins_dst_tag | input | 6 | Destination register tag |
| cmp_valid | input | 1 | A producer completes this cycle |
| cmp_tag | input | 6 | Register written by the completing producer |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | 8 | Squash point; younger entries are removed |
| entry_ready | output | NUM_ENTRIES | Entry occupied with all operands ready |
| entry_busy | output | NUM_ENTRIES | Entry occupied |
| alloc_err | output | 1 | Destination allocated while waiters remain |

## Verification
Two pairs of functions can land on the same edge. The first is an insertion and a completion that name the same register. The second is a destination allocation and a completion on the same register. The bench drives both pairs in a single cycle.

For the first pair, a later completion on the register is not needed to make the new entry ready, and the entry is judged on that. For the second pair, the scoreboard is probed after the fact by inserting a fresh consumer of the register: it must wait. The bench also combines a squash with an insertion younger than the squash point, and checks at the ports that the insertion left no occupied slot.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    localparam int TAG_W = 6;
    localparam int SEQ_W = 8;
    localparam int NSRC  = 2;

    typedef logic [TAG_W-1:0] ptag_t;
    typedef logic [SEQ_W-1:0] seq_t;

    // A register reference with a qualifier (completion or allocation).
    typedef struct packed {
        logic  valid;
        ptag_t tag;
    } regref_t;

    // One source operand held in an entry.
    typedef struct packed {
        logic  pend;
        ptag_t tag;
    } opnd_t;

    // Squash request.
    typedef struct packed {
        logic valid;
        seq_t seq;
    } flush_t;

    function automatic logic tag_tracked(ptag_t t, int npregs);
        return (int'(t) < npregs);
    endfunction

    function automatic logic seq_younger(seq_t a, seq_t b);
        return (a > b);
    endfunction

    function automatic logic ref_hits(regref_t r, ptag_t t);
        return r.valid && (r.tag == t);
    endfunction

endpackage

// File: rtl/sbw_scoreboard.sv
module sbw_scoreboard
    import sbw_pkg::*;
#(
    parameter int NUM_PREGS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  regref_t              set_i,
    input  regref_t              clr_i,
    input  ptag_t   [NSRC-1:0]   look_tag_i,
    output logic    [NSRC-1:0]   look_rdy_o
);

    logic [NUM_PREGS-1:0] sb_q;

    // Allocation (clear) is the newer event and overrides a completion (set).
    always_ff @(posedge clk) begin
        if (rst) begin
            sb_q <= '0;
        end else begin
            for (int b = 0; b < NUM_PREGS; b++) begin
                if (ref_hits(clr_i, ptag_t'(b))) begin
                    sb_q[b] <= 1'b0;
                end else if (ref_hits(set_i, ptag_t'(b))) begin
                    sb_q[b] <= 1'b1;
                end
            end
        end
    end

    // Untracked tags match no bit and read as not ready.
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            look_rdy_o[s] = 1'b0;
            for (int b = 0; b < NUM_PREGS; b++) begin
                if (look_tag_i[s] == ptag_t'(b)) begin
                    look_rdy_o[s] = sb_q[b];
                end
            end
        end
    end

    p_reset_notready_r1: assert property (@(posedge clk)
        $past(rst) |-> (sb_q == '0));

    p_untracked_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (set_i.valid && !tag_tracked(set_i.tag, NUM_PREGS) && !clr_i.valid)
        |=> $stable(sb_q));

    for (genvar g = 0; g < NUM_PREGS; g++) begin : g_chk
        p_done_sets_r5: assert property (@(posedge clk) disable iff (rst)
            (ref_hits(set_i, ptag_t'(g)) && !ref_hits(clr_i, ptag_t'(g)))
            |=> sb_q[g]);
        p_alloc_clears_r8: assert property (@(posedge clk) disable iff (rst)
            ref_hits(clr_i, ptag_t'(g)) |=> !sb_q[g]);
    end

endmodule

// File: rtl/sbw_entry.sv
module sbw_entry
    import sbw_pkg::*;
#(
    parameter int NUM_PREGS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  seq_t                load_seq_i,
    input  opnd_t  [NSRC-1:0]   load_ops_i,
    input  regref_t             wake_i,
    input  flush_t              flush_i,
    output logic                busy_o,
    output logic                ready_o,
    output opnd_t  [NSRC-1:0]   ops_o
);

    logic              valid_q;
    logic              rdy_q;
    seq_t              seq_q;
    opnd_t [NSRC-1:0]  ops_q;
    logic              kill;
    logic              any_pend;

    always_comb begin
        kill = flush_i.valid && valid_q && seq_younger(seq_q, flush_i.seq);
        any_pend = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            any_pend = any_pend | ops_q[s].pend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rdy_q   <= 1'b0;
            seq_q   <= '0;
            ops_q   <= '0;
        end else begin
            rdy_q <= valid_q && !any_pend && !load_i && !kill;
            if (load_i) begin
                valid_q <= 1'b1;
                seq_q   <= load_seq_i;
                ops_q   <= load_ops_i;
            end else if (kill) begin
                valid_q <= 1'b0;
                for (int s = 0; s < NSRC; s++) begin
                    ops_q[s].pend <= 1'b0;
                end
            end else begin
                for (int s = 0; s < NSRC; s++) begin
                    if (ops_q[s].pend && ref_hits(wake_i, ops_q[s].tag)) begin
                        ops_q[s].pend <= 1'b0;
                    end
                end
            end
        end
    end

    assign busy_o  = valid_q;
    assign ready_o = rdy_q;
    assign ops_o   = ops_q;

    p_ready_rises_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !any_pend && !load_i && !kill) |=> rdy_q);

    p_ready_clean_r6: assert property (@(posedge clk) disable iff (rst)
        rdy_q |-> (valid_q && !any_pend));

    p_squash_kills_r10: assert property (@(posedge clk) disable iff (rst)
        (kill && !load_i) |=> (!valid_q && !rdy_q && !any_pend));

    p_reload_drops_r11: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !rdy_q);

    for (genvar s = 0; s < NSRC; s++) begin : g_chk
        p_wake_clears_r5: assert property (@(posedge clk) disable iff (rst)
            (ops_q[s].pend && ref_hits(wake_i, ops_q[s].tag) && !load_i)
            |=> !ops_q[s].pend);
        p_untracked_idle_r4: assert property (@(posedge clk) disable iff (rst)
            ops_q[s].pend |-> tag_tracked(ops_q[s].tag, NUM_PREGS));
    end

endmodule

// File: rtl/sbw_alloc_guard.sv
module sbw_alloc_guard
    import sbw_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_PREGS   = 32
) (
    input  logic                                clk,
    input  logic                                rst,
    input  regref_t                             dst_i,
    input  logic  [NUM_ENTRIES-1:0]             busy_i,
    input  opnd_t [NUM_ENTRIES-1:0][NSRC-1:0]   ops_i,
    output logic                                err_o
);

    logic has_waiter;
    logic err_q;

    always_comb begin
        has_waiter = 1'b0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            for (int s = 0; s < NSRC; s++) begin
                if (busy_i[e] && ops_i[e][s].pend && ops_i[e][s].tag == dst_i.tag) begin
                    has_waiter = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= dst_i.valid && tag_tracked(dst_i.tag, NUM_PREGS) && has_waiter;
        end
    end

    assign err_o = err_q;

    p_err_needs_alloc_r9: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(dst_i.valid));

    p_err_untracked_r4: assert property (@(posedge clk) disable iff (rst)
        (dst_i.valid && !tag_tracked(dst_i.tag, NUM_PREGS)) |=> !err_o);

endmodule

// File: rtl/sbw_wakeup_unit.sv
module sbw_wakeup_unit
    import sbw_pkg::*;
#(
    parameter int  NUM_ENTRIES = 8,
    parameter int  NUM_PREGS   = 32,
    localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ins_valid,
    input  logic [IDX_W-1:0]          ins_slot,
    input  logic [SEQ_W-1:0]          ins_seq,
    input  logic [NSRC*TAG_W-1:0]     ins_src_tags,
    input  logic [NSRC-1:0]           ins_src_rdy,
    input  logic                      ins_dst_valid,
    input  logic [TAG_W-1:0]          ins_dst_tag,
    input  logic                      cmp_valid,
    input  logic [TAG_W-1:0]          cmp_tag,
    input  logic                      sq_valid,
    input  logic [SEQ_W-1:0]          sq_seq,
    output logic [NUM_ENTRIES-1:0]    entry_ready,
    output logic [NUM_ENTRIES-1:0]    entry_busy,
    output logic                      alloc_err
);

    regref_t                              wake;
    regref_t                              alloc;
    flush_t                               flush;
    logic                                 insert_ok;
    ptag_t  [NSRC-1:0]                    src_tag;
    logic   [NSRC-1:0]                    sb_rdy;
    opnd_t  [NSRC-1:0]                    new_ops;
    opnd_t  [NUM_ENTRIES-1:0][NSRC-1:0]   ent_ops;

    always_comb begin
        wake      = '{valid: cmp_valid, tag: cmp_tag};
        flush     = '{valid: sq_valid, seq: sq_seq};
        insert_ok = ins_valid && !(sq_valid && seq_younger(ins_seq, sq_seq));
        alloc     = '{valid: insert_ok && ins_dst_valid, tag: ins_dst_tag};
        for (int s = 0; s < NSRC; s++) begin
            src_tag[s]      = ins_src_tags[s*TAG_W +: TAG_W];
            new_ops[s].tag  = src_tag[s];
            new_ops[s].pend = !ins_src_rdy[s]
                            && tag_tracked(src_tag[s], NUM_PREGS)
                            && !sb_rdy[s]
                            && !ref_hits(wake, src_tag[s]);
        end
    end

    sbw_scoreboard #(
        .NUM_PREGS (NUM_PREGS)
    ) u_sb (
        .clk        (clk),
        .rst        (rst),
        .set_i      (wake),
        .clr_i      (alloc),
        .look_tag_i (src_tag),
        .look_rdy_o (sb_rdy)
    );

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        sbw_entry #(
            .NUM_PREGS (NUM_PREGS)
        ) u_ent (
            .clk        (clk),
            .rst        (rst),
            .load_i     (insert_ok && (ins_slot == IDX_W'(e))),
            .load_seq_i (ins_seq),
            .load_ops_i (new_ops),
            .wake_i     (wake),
            .flush_i    (flush),
            .busy_o     (entry_busy[e]),
            .ready_o    (entry_ready[e]),
            .ops_o      (ent_ops[e])
        );
    end

    sbw_alloc_guard #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .NUM_PREGS   (NUM_PREGS)
    ) u_guard (
        .clk    (clk),
        .rst    (rst),
        .dst_i  (alloc),
        .busy_i (entry_busy),
        .ops_i  (ent_ops),
        .err_o  (alloc_err)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_chk
        p_rename_ready_r2: assert property (@(posedge clk) disable iff (rst)
            (insert_ok && ins_src_rdy[s]) |=> !ent_ops[$past(ins_slot)][s].pend);
        p_recheck_r3: assert property (@(posedge clk) disable iff (rst)
            (insert_ok && sb_rdy[s]) |=> !ent_ops[$past(ins_slot)][s].pend);
        p_wake_wins_r7: assert property (@(posedge clk) disable iff (rst)
            (insert_ok && ref_hits(wake, src_tag[s]))
            |=> !ent_ops[$past(ins_slot)][s].pend);
    end

    p_dropped_insert_r10: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !insert_ok && !entry_busy[ins_slot]) |=> !entry_busy[$past(ins_slot)]);

endmodule

// File: tb/sbw_wakeup_unit_tb.sv
module sbw_wakeup_unit_tb;

    typedef struct packed {
        logic [3:0] req;
        logic       ins_v;
        logic [2:0] slot;
        logic [7:0] seq;
        logic [5:0] s0;
        logic [5:0] s1;
        logic [1:0] rdy;
        logic       dst_v;
        logic [5:0] dst;
        logic       cmp_v;
        logic [5:0] ctag;
        logic       sq_v;
        logic [7:0] sqs;
        logic [7:0] exp_rdy;
        logic       exp_err;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        // R2: slot0 waits on p3 and p4
        '{4'd2,  1'b1, 3'd0, 8'd10, 6'd3,  6'd4,  2'b00, 1'b1, 6'd10, 1'b0, 6'd0,  1'b0, 8'd0,  8'h00, 1'b0},
        // R4: slot1 waits on p3 only, p40 untracked
        '{4'd4,  1'b1, 3'd1, 8'd11, 6'd3,  6'd40, 2'b00, 1'b1, 6'd11, 1'b0, 6'd0,  1'b0, 8'd0,  8'h00, 1'b0},
        // R5: completion of p3 readies slot1
        '{4'd5,  1'b0, 3'd0, 8'd0,  6'd0,  6'd0,  2'b00, 1'b0, 6'd0,  1'b1, 6'd3,  1'b0, 8'd0,  8'h02, 1'b0},
        // R3: p3 found set at dispatch, p5 rename-ready
        '{4'd3,  1'b1, 3'd2, 8'd12, 6'd3,  6'd5,  2'b10, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 8'd0,  8'h06, 1'b0},
        // R7: insert on p6 with same-cycle completion of p6
        '{4'd7,  1'b1, 3'd3, 8'd13, 6'd6,  6'd6,  2'b00, 1'b1, 6'd12, 1'b1, 6'd6,  1'b0, 8'd0,  8'h0E, 1'b0},
        // R4: completion of untracked p40 changes nothing
        '{4'd4,  1'b0, 3'd0, 8'd0,  6'd0,  6'd0,  2'b00, 1'b0, 6'd0,  1'b1, 6'd40, 1'b0, 8'd0,  8'h0E, 1'b0},
        // R9: allocate p4 while slot0 waits on it
        '{4'd9,  1'b1, 3'd4, 8'd14, 6'd4,  6'd4,  2'b00, 1'b1, 6'd4,  1'b0, 6'd0,  1'b0, 8'd0,  8'h0E, 1'b1},
        // R5: completion of p4 wakes two entries
        '{4'd5,  1'b0, 3'd0, 8'd0,  6'd0,  6'd0,  2'b00, 1'b0, 6'd0,  1'b1, 6'd4,  1'b0, 8'd0,  8'h1F, 1'b0},
        // R3: p4 now set in scoreboard
        '{4'd3,  1'b1, 3'd5, 8'd15, 6'd4,  6'd4,  2'b00, 1'b1, 6'd20, 1'b0, 6'd0,  1'b0, 8'd0,  8'h3F, 1'b0},
        // R9: allocate p4 with no waiters, sources untracked
        '{4'd9,  1'b1, 3'd6, 8'd16, 6'd40, 6'd41, 2'b00, 1'b1, 6'd4,  1'b0, 6'd0,  1'b0, 8'd0,  8'h7F, 1'b0},
        // R8: p4 was cleared by the allocation, slot7 waits
        '{4'd8,  1'b1, 3'd7, 8'd17, 6'd4,  6'd41, 2'b00, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 8'd0,  8'h7F, 1'b0},
        // R10: squash at 14 removes slots 5,6,7
        '{4'd10, 1'b0, 3'd0, 8'd0,  6'd0,  6'd0,  2'b00, 1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 8'd14, 8'h1F, 1'b0},
        // R8: allocation and completion of p4 together
        '{4'd8,  1'b1, 3'd5, 8'd15, 6'd3,  6'd3,  2'b00, 1'b1, 6'd4,  1'b1, 6'd4,  1'b0, 8'd0,  8'h3F, 1'b0},
        // R8: probe shows p4 ended clear
        '{4'd8,  1'b1, 3'd6, 8'd16, 6'd4,  6'd3,  2'b00, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 8'd0,  8'h3F, 1'b0},
        // R10: squash at 15 with younger insert: insert dropped, slot6 removed
        '{4'd10, 1'b1, 3'd7, 8'd16, 6'd3,  6'd3,  2'b00, 1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 8'd15, 8'h3F, 1'b0},
        // R11: reinsert into slot0 with a pending operand
        '{4'd11, 1'b1, 3'd0, 8'd14, 6'd7,  6'd3,  2'b00, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 8'd0,  8'h3E, 1'b0},
        // R10: squash that removes nothing keeps slot0 pending
        '{4'd10, 1'b0, 3'd0, 8'd0,  6'd0,  6'd0,  2'b00, 1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 8'd20, 8'h3E, 1'b0},
        // R5: completion of p7 wakes the survivor
        '{4'd5,  1'b0, 3'd0, 8'd0,  6'd0,  6'd0,  2'b00, 1'b0, 6'd0,  1'b1, 6'd7,  1'b0, 8'd0,  8'h3F, 1'b0},
        // R10: squashed waiter on p4 is not woken
        '{4'd10, 1'b0, 3'd0, 8'd0,  6'd0,  6'd0,  2'b00, 1'b0, 6'd0,  1'b1, 6'd4,  1'b0, 8'd0,  8'h3F, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid;
    logic [2:0]  ins_slot;
    logic [7:0]  ins_seq;
    logic [11:0] ins_src_tags;
    logic [1:0]  ins_src_rdy;
    logic        ins_dst_valid;
    logic [5:0]  ins_dst_tag;
    logic        cmp_valid;
    logic [5:0]  cmp_tag;
    logic        sq_valid;
    logic [7:0]  sq_seq;
    logic [7:0]  entry_ready;
    logic [7:0]  entry_busy;
    logic        alloc_err;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sbw_wakeup_unit u_dut (
        .clk           (clk),
        .rst           (rst),
        .ins_valid     (ins_valid),
        .ins_slot      (ins_slot),
        .ins_seq       (ins_seq),
        .ins_src_tags  (ins_src_tags),
        .ins_src_rdy   (ins_src_rdy),
        .ins_dst_valid (ins_dst_valid),
        .ins_dst_tag   (ins_dst_tag),
        .cmp_valid     (cmp_valid),
        .cmp_tag       (cmp_tag),
        .sq_valid      (sq_valid),
        .sq_seq        (sq_seq),
        .entry_ready   (entry_ready),
        .entry_busy    (entry_busy),
        .alloc_err     (alloc_err)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        ins_valid     = 1'b0;
        ins_slot      = '0;
        ins_seq       = '0;
        ins_src_tags  = '0;
        ins_src_rdy   = '0;
        ins_dst_valid = 1'b0;
        ins_dst_tag   = '0;
        cmp_valid     = 1'b0;
        cmp_tag       = '0;
        sq_valid      = 1'b0;
        sq_seq        = '0;
    endtask

    task automatic drive(input vec_t v);
        ins_valid     = v.ins_v;
        ins_slot      = v.slot;
        ins_seq       = v.seq;
        ins_src_tags  = {v.s1, v.s0};
        ins_src_rdy   = v.rdy;
        ins_dst_valid = v.dst_v;
        ins_dst_tag   = v.dst;
        cmp_valid     = v.cmp_v;
        cmp_tag       = v.ctag;
        sq_valid      = v.sq_v;
        sq_seq        = v.sqs;
    endtask

    task automatic insert(input logic [2:0] slot, input logic [7:0] seq,
                          input logic [5:0] s0, input logic [5:0] s1);
        idle();
        ins_valid    = 1'b1;
        ins_slot     = slot;
        ins_seq      = seq;
        ins_src_tags = {s1, s0};
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state out of reset
        check(1, entry_ready, 8'h00, "ready after reset");
        check(1, entry_busy, 8'h00, "busy after reset");
        check(1, alloc_err, 1'b0, "error after reset");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            @(negedge clk);
            idle();
            check(int'(TBL[i].req), alloc_err, TBL[i].exp_err, $sformatf("alloc_err step %0d", i));
            @(negedge clk);
            check(int'(TBL[i].req), entry_ready, TBL[i].exp_rdy, $sformatf("ready step %0d", i));
        end

        // R10: occupancy after the squashes and the dropped insert
        check(10, entry_busy, 8'h3F, "busy after squashes");
        // R9: error pulse lasts one cycle
        check(9, alloc_err, 1'b0, "error pulse ended");

        // R6: wake timing, slot6 waits on p9
        insert(3'd6, 8'd21, 6'd9, 6'd9);
        @(negedge clk);
        idle();
        cmp_valid = 1'b1;
        cmp_tag   = 6'd9;
        @(negedge clk);
        idle();
        check(6, entry_ready[6], 1'b0, "not ready one edge after wake");
        @(negedge clk);
        check(6, entry_ready[6], 1'b1, "ready two edges after wake");

        // R6: insert timing with all sources rename-ready
        insert(3'd7, 8'd22, 6'd9, 6'd9);
        ins_src_rdy = 2'b11;
        @(negedge clk);
        idle();
        check(6, entry_ready[7], 1'b0, "not ready one edge after insert");
        @(negedge clk);
        check(6, entry_ready[7], 1'b1, "ready two edges after insert");

        // R11: reinsert into a ready slot drops ready at the next edge
        insert(3'd7, 8'd23, 6'd9, 6'd9);
        ins_src_rdy = 2'b11;
        @(negedge clk);
        idle();
        check(11, entry_ready[7], 1'b0, "ready dropped on reinsert");

        // R1: reset mid-run clears the scoreboard (p3 was ready)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(1, entry_ready, 8'h00, "ready after mid-run reset");
        check(1, entry_busy, 8'h00, "busy after mid-run reset");
        insert(3'd0, 8'd1, 6'd3, 6'd3);
        @(negedge clk);
        idle();
        @(negedge clk);
        check(1, entry_ready[0], 1'b0, "p3 not ready after reset");
        check(1, entry_busy[0], 1'b1, "slot0 occupied after insert");

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule